// File: doc/BRIEF.md
# Timed PHY Reset Sequencer

This block brings an external Ethernet PHY out of reset along a fixed timed path and tells the rest of the MAC when the management bus may be used. When a start strobe is accepted, the block first gives the MAC core reset a single-cycle pulse. It then keeps the PHY reset line released for a settle time, asserts the line for a pulse time, releases it, and waits a further recovery time. Only after that wait does it raise a done flag, which means MDIO accesses are now safe. Each of the three times is given in microseconds. A cycles-per-microsecond setting converts them into clock cycles, so the same block fits any core clock.

The block also owns the MAC interface reset. This reset is held asserted from power-on until the first accepted start. After that, it gives a single-cycle pulse each time a new speed/duplex setting is written. Presence enables let an integration leave out any of the three resets: a missing reset loses its pulse and the sequence carries on.

Top module: `phy_reset_sequencer`

## Requirements
- R1: After power-on reset and before any start, `phyReset`, `busy` and `done` are 0, while `coreReset` and `ifcReset` are 1 and stay 1.
- R2: A start accepted while idle raises `busy` at the next clock edge (edge E0). `coreReset` is 1 for exactly the cycle that follows E0 and is 0 from edge E0+1, when `corePresent` is 1. When `corePresent` is 0, `coreReset` is 0 from E0 with no pulse.
- R3: With the PHY present, let C be the effective cycles per microsecond. `phyReset` stays 0 until edge E0+1+pre·C. It is then 1 for exactly pulse·C cycles and returns to 0.
- R4: `done` falls at E0 and rises, together with the fall of `busy`, at edge E0+1+(pre+pulse+post)·C. It holds at 1 until the next accepted start. `done` and `busy` are never 1 together.
- R5: A delay of zero microseconds removes its wait completely. A zero pulse delay means `phyReset` is never asserted in that run.
- R6: A cycles-per-microsecond value of 0 is taken as 1.
- R7: A start strobe that arrives while `busy` is 1 has no effect on any output or on the timing of the run in progress.
- R8: With `phyPresent` at 0, `phyReset` stays 0 and `done` rises at edge E0+1, whatever the delays are.
- R9: Once released by a first start, `ifcReset` is 1 for exactly one cycle after each clock edge that samples `cfgWrite` high with `ifcPresent` at 1. With `ifcPresent` at 0 it stays 0.
- R10: Delays and the cycles-per-microsecond value are sampled at the accepted start. Changes to them during a run do not affect that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| start | input | 1 | Request to run the reset sequence |
| cfgWrite | input | 1 | Strobe: a new speed/duplex setting was written |
| preDelayUs | input | 32 | Released-hold time before the PHY pulse, microseconds |
| pulseDelayUs | input | 32 | PHY reset assertion time, microseconds |
| postDelayUs | input | 32 | Recovery time before management access, microseconds |
| cyclesPerUs | input | 16 | Clock cycles per microsecond (0 treated as 1) |
| phyPresent | input | 1 | PHY reset line is wired |
| corePresent | input | 1 | MAC core reset is wired |
| ifcPresent | input | 1 | MAC interface reset is wired |
| phyReset | output | 1 | Active-high PHY reset |
| coreReset | output | 1 | Active-high MAC core reset |
| ifcReset | output | 1 | Active-high MAC interface reset |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished; MDIO access is safe |

## Verification
If the prescaler or the microsecond counter goes wrong, the fault shows up as an edge of `phyReset` or `done` at the wrong cycle. The error grows with every microsecond, so a check on the exact edge cycle catches it at the first transition after the fault. A wrong sequencer state appears within one cycle as a `phyReset` that is high while `busy` is low, as `done` and `busy` high together, or as a core or interface pulse longer than one cycle. The bench therefore predicts the exact cycle of every rising and falling edge on the reset outputs and on `done`, and it flags any edge that it did not predict.

// File: rtl/phy_rstseq_pkg.sv
package phy_rstseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CORE,
    ST_PRE,
    ST_PULSE,
    ST_POST
  } seqState_t;

  typedef enum logic [1:0] {
    SEL_PRE,
    SEL_PULSE,
    SEL_POST
  } delaySel_t;

  // Strobes from the sequencer to the timing datapath
  typedef struct packed {
    logic      capture;  // sample delays and rate at an accepted start
    logic      load;     // start a new wait from the selected delay
    delaySel_t sel;
  } dpCtrl_t;

endpackage

// File: rtl/phy_rstseq_timer.sv
module phy_rstseq_timer
  import phy_rstseq_pkg::*;
#(
  parameter int US_W  = 32,
  parameter int CPU_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctl,
  input  logic [US_W-1:0]  preUs,
  input  logic [US_W-1:0]  pulseUs,
  input  logic [US_W-1:0]  postUs,
  input  logic [CPU_W-1:0] cyclesPerUs,
  output logic             preZero,
  output logic             pulseZero,
  output logic             postZero,
  output logic             lastTick
);

  localparam logic [CPU_W-1:0] CPU_ONE = CPU_W'(1);
  localparam logic [US_W-1:0]  US_ONE  = US_W'(1);

  logic [US_W-1:0]  snapPre, snapPulse, snapPost;
  logic [CPU_W-1:0] snapCpu;
  logic [CPU_W-1:0] prescale;
  logic [US_W-1:0]  usLeft;
  logic [CPU_W-1:0] cpuEff;
  logic [CPU_W-1:0] cpuLast;
  logic [US_W-1:0]  loadVal;
  logic             usTick;

  assign cpuEff  = (snapCpu == '0) ? CPU_ONE : snapCpu;
  assign cpuLast = cpuEff - CPU_ONE;
  assign usTick  = (prescale == cpuLast);

  always_comb begin
    case (ctl.sel)
      SEL_PULSE: loadVal = snapPulse;
      SEL_POST:  loadVal = snapPost;
      default:   loadVal = snapPre;
    endcase
  end

  // Snapshot taken at an accepted start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapPre   <= '0;
      snapPulse <= '0;
      snapPost  <= '0;
      snapCpu   <= '0;
    end else if (ctl.capture) begin
      snapPre   <= preUs;
      snapPulse <= pulseUs;
      snapPost  <= postUs;
      snapCpu   <= cyclesPerUs;
    end
  end

  // Microsecond prescaler and microsecond down counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescale <= '0;
      usLeft   <= '0;
    end else if (ctl.load) begin
      prescale <= '0;
      usLeft   <= loadVal;
    end else if (usLeft != '0) begin
      if (usTick) begin
        prescale <= '0;
        usLeft   <= usLeft - US_ONE;
      end else begin
        prescale <= prescale + CPU_ONE;
      end
    end
  end

  assign preZero   = (snapPre == '0);
  assign pulseZero = (snapPulse == '0);
  assign postZero  = (snapPost == '0);
  assign lastTick  = (usLeft == US_ONE) && usTick;

  AST_PRESCALE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    prescale < cpuEff); // R6

  AST_COUNT_PARKS: assert property (@(posedge clk) disable iff (!rstN)
    (usLeft == '0 && !ctl.load) |=> (usLeft == '0)); // R5

  AST_SNAP_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> $stable(snapPulse) && $stable(snapCpu)); // R10

endmodule

// File: rtl/phy_rstseq_ctrl.sv
module phy_rstseq_ctrl
  import phy_rstseq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    cfgWrite,
  input  logic    phyPresent,
  input  logic    corePresent,
  input  logic    ifcPresent,
  input  logic    preZero,
  input  logic    pulseZero,
  input  logic    postZero,
  input  logic    lastTick,
  output dpCtrl_t ctl,
  output logic    phyReset,
  output logic    coreReset,
  output logic    ifcReset,
  output logic    busy,
  output logic    done
);

  seqState_t state, stateNxt;
  seqState_t afterCore, afterPre, afterPulse, target;
  logic      advance;
  logic      startAcc;
  logic      released, releasedNxt;
  logic      phyNxt, busyNxt, doneNxt, coreNxt, ifcNxt;

  assign startAcc    = start && (state == ST_IDLE);
  assign releasedNxt = released || startAcc;

  // Next wait in order; ST_IDLE means the run is over
  assign afterPulse = postZero ? ST_IDLE : ST_POST;
  assign afterPre   = pulseZero ? afterPulse : ST_PULSE;
  assign afterCore  = !phyPresent ? ST_IDLE : (preZero ? afterPre : ST_PRE);

  always_comb begin
    advance = 1'b0;
    target  = ST_IDLE;
    case (state)
      ST_CORE:  begin advance = 1'b1;     target = afterCore;  end
      ST_PRE:   begin advance = lastTick; target = afterPre;   end
      ST_PULSE: begin advance = lastTick; target = afterPulse; end
      ST_POST:  begin advance = lastTick; target = ST_IDLE;    end
      default:  ;
    endcase
  end

  always_comb begin
    stateNxt = state;
    ctl      = '0;
    phyNxt   = phyReset;
    busyNxt  = busy;
    doneNxt  = done;
    if (startAcc) begin
      stateNxt    = ST_CORE;
      ctl.capture = 1'b1;
      busyNxt     = 1'b1;
      doneNxt     = 1'b0;
    end else if (advance) begin
      stateNxt = target;
      if (state == ST_PULSE) phyNxt = 1'b0;
      case (target)
        ST_PRE:   begin ctl.load = 1'b1; ctl.sel = SEL_PRE; end
        ST_PULSE: begin ctl.load = 1'b1; ctl.sel = SEL_PULSE; phyNxt = 1'b1; end
        ST_POST:  begin ctl.load = 1'b1; ctl.sel = SEL_POST; end
        default:  begin busyNxt = 1'b0; doneNxt = 1'b1; end
      endcase
    end
  end

  always_comb begin
    if (startAcc)              coreNxt = corePresent;
    else if (state == ST_CORE) coreNxt = 1'b0;
    else                       coreNxt = coreReset;
    ifcNxt = releasedNxt ? (cfgWrite && ifcPresent) : 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      released  <= 1'b0;
      phyReset  <= 1'b0;
      coreReset <= 1'b1;
      ifcReset  <= 1'b1;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      state     <= stateNxt;
      released  <= releasedNxt;
      phyReset  <= phyNxt;
      coreReset <= coreNxt;
      ifcReset  <= ifcNxt;
      busy      <= busyNxt;
      done      <= doneNxt;
    end
  end

  AST_PHY_IN_RUN: assert property (@(posedge clk) disable iff (!rstN)
    phyReset |-> busy); // R3

  AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R4

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done); // R4

  AST_CORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (coreReset && released) |=> !coreReset); // R2

  AST_IFC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (ifcReset && released && !cfgWrite) |=> !ifcReset); // R9

  AST_BUSY_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && state != ST_CORE && !lastTick) |=> busy); // R7

  AST_PHY_LOW_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> !phyReset); // R3

endmodule

// File: rtl/phy_reset_sequencer.sv
module phy_reset_sequencer
  import phy_rstseq_pkg::*;
#(
  parameter int US_W  = 32,
  parameter int CPU_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             cfgWrite,
  input  logic [US_W-1:0]  preDelayUs,
  input  logic [US_W-1:0]  pulseDelayUs,
  input  logic [US_W-1:0]  postDelayUs,
  input  logic [CPU_W-1:0] cyclesPerUs,
  input  logic             phyPresent,
  input  logic             corePresent,
  input  logic             ifcPresent,
  output logic             phyReset,
  output logic             coreReset,
  output logic             ifcReset,
  output logic             busy,
  output logic             done
);

  dpCtrl_t ctl;
  logic    preZero, pulseZero, postZero, lastTick;

  phy_rstseq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .cfgWrite   (cfgWrite),
    .phyPresent (phyPresent),
    .corePresent(corePresent),
    .ifcPresent (ifcPresent),
    .preZero    (preZero),
    .pulseZero  (pulseZero),
    .postZero   (postZero),
    .lastTick   (lastTick),
    .ctl        (ctl),
    .phyReset   (phyReset),
    .coreReset  (coreReset),
    .ifcReset   (ifcReset),
    .busy       (busy),
    .done       (done)
  );

  phy_rstseq_timer #(
    .US_W (US_W),
    .CPU_W(CPU_W)
  ) u_timer (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .preUs      (preDelayUs),
    .pulseUs    (pulseDelayUs),
    .postUs     (postDelayUs),
    .cyclesPerUs(cyclesPerUs),
    .preZero    (preZero),
    .pulseZero  (pulseZero),
    .postZero   (postZero),
    .lastTick   (lastTick)
  );

endmodule

// File: tb/phy_reset_sequencer_test.sv
module phy_reset_sequencer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        cfgWrite = 1'b0;
  logic [31:0] preDelayUs = '0;
  logic [31:0] pulseDelayUs = '0;
  logic [31:0] postDelayUs = '0;
  logic [15:0] cyclesPerUs = 16'd1;
  logic        phyPresent = 1'b1;
  logic        corePresent = 1'b1;
  logic        ifcPresent = 1'b1;
  logic        phyReset, coreReset, ifcReset, busy, done;

  always #5 clk = ~clk;

  phy_reset_sequencer uut (
    .clk(clk), .rstN(rstN), .start(start), .cfgWrite(cfgWrite),
    .preDelayUs(preDelayUs), .pulseDelayUs(pulseDelayUs),
    .postDelayUs(postDelayUs), .cyclesPerUs(cyclesPerUs),
    .phyPresent(phyPresent), .corePresent(corePresent),
    .ifcPresent(ifcPresent), .phyReset(phyReset), .coreReset(coreReset),
    .ifcReset(ifcReset), .busy(busy), .done(done)
  );

  int    cyc = 0;
  int    vectors = 0;
  int    fails = 0;
  string curReq = "R1";
  logic  coreModel = 1'b1;

  // Expected edge cycles, one queue per event kind
  int qCoreUp[$], qCoreDn[$], qPhyUp[$], qPhyDn[$], qDoneUp[$], qIfcUp[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic checkBit(string req, string what, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
    end
  endtask

  // Monitor: pops the expected cycle of each observed edge
  task automatic seeEdge(int kind, string what);
    int exp;
    logic have;
    have = 1'b1;
    exp = -1;
    case (kind)
      0: if (qCoreUp.size() > 0) exp = qCoreUp.pop_front(); else have = 1'b0;
      1: if (qCoreDn.size() > 0) exp = qCoreDn.pop_front(); else have = 1'b0;
      2: if (qPhyUp.size() > 0)  exp = qPhyUp.pop_front();  else have = 1'b0;
      3: if (qPhyDn.size() > 0)  exp = qPhyDn.pop_front();  else have = 1'b0;
      4: if (qDoneUp.size() > 0) exp = qDoneUp.pop_front(); else have = 1'b0;
      default: if (qIfcUp.size() > 0) exp = qIfcUp.pop_front(); else have = 1'b0;
    endcase
    vectors++;
    if (!have || exp != cyc) begin
      fails++;
      $display("FAIL %s %s edge: got cycle %0d expected cycle %0d", curReq, what, cyc, exp);
    end
  endtask

  logic monOn = 1'b0;
  logic primed = 1'b0;
  logic pCore, pPhy, pDone, pIfc;

  always @(negedge clk) begin
    if (monOn) begin
      if (primed) begin
        if (coreReset && !pCore) seeEdge(0, "coreReset rise");
        if (!coreReset && pCore) seeEdge(1, "coreReset fall");
        if (phyReset && !pPhy)   seeEdge(2, "phyReset rise");
        if (!phyReset && pPhy)   seeEdge(3, "phyReset fall");
        if (done && !pDone)      seeEdge(4, "done rise");
        if (ifcReset && !pIfc)   seeEdge(5, "ifcReset rise");
      end
      primed <= 1'b1;
      pCore  <= coreReset;
      pPhy   <= phyReset;
      pDone  <= done;
      pIfc   <= ifcReset;
    end
  end

  task automatic finishRun();
    int left;
    left = qCoreUp.size() + qCoreDn.size() + qPhyUp.size() + qPhyDn.size()
         + qDoneUp.size() + qIfcUp.size();
    vectors++;
    if (left != 0) begin
      fails++;
      $display("FAIL R4 pending edges: got %0d missing expected 0", left);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  // Driver: start a run and push every predicted edge
  task automatic runSeq(string req, int pre, int pulse, int post, int cpu,
                        logic core, logic phy, logic busyStart);
    int s, e0, c, doneAt;
    curReq = req;
    @(posedge clk); #1;
    preDelayUs = pre; pulseDelayUs = pulse; postDelayUs = post;
    cyclesPerUs = cpu[15:0]; corePresent = core; phyPresent = phy;
    start = 1'b1;
    s = cyc;
    e0 = s + 1;
    c = (cpu == 0) ? 1 : cpu;
    if (core) begin
      if (!coreModel) qCoreUp.push_back(e0);
      qCoreDn.push_back(e0 + 1);
    end else if (coreModel) begin
      qCoreDn.push_back(e0);
    end
    coreModel = 1'b0;
    if (phy && pulse != 0) begin
      qPhyUp.push_back(e0 + 1 + pre * c);
      qPhyDn.push_back(e0 + 1 + (pre + pulse) * c);
    end
    doneAt = phy ? e0 + 1 + (pre + pulse + post) * c : e0 + 1;
    qDoneUp.push_back(doneAt);
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    checkBit("R2", "busy after start", busy, 1'b1);
    checkBit("R4", "done cleared by start", done, 1'b0);
    if (busyStart) begin
      // R7 / R10: a new start and new delays during the run are ignored
      repeat (2) @(posedge clk);
      #1;
      start = 1'b1;
      preDelayUs = 32'd40; pulseDelayUs = 32'd40; postDelayUs = 32'd40;
      cyclesPerUs = 16'd7;
      @(posedge clk); #1;
      start = 1'b0;
      @(negedge clk);
      checkBit("R7", "busy kept on ignored start", busy, 1'b1);
    end
    while (cyc < doneAt + 2) @(negedge clk);
    checkBit("R4", "busy low after run", busy, 1'b0);
    checkBit("R4", "done high after run", done, 1'b1);
    checkBit("R3", "phyReset low after run", phyReset, 1'b0);
  endtask

  task automatic cfgPulse(logic present);
    int s;
    curReq = "R9";
    @(posedge clk); #1;
    ifcPresent = present;
    cfgWrite = 1'b1;
    s = cyc;
    if (present) qIfcUp.push_back(s + 1);
    @(posedge clk); #1;
    cfgWrite = 1'b0;
    @(negedge clk);
    checkBit("R9", "ifcReset pulse", ifcReset, present);
    @(negedge clk);
    checkBit("R9", "ifcReset after pulse", ifcReset, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    checkBit("R1", "phyReset at reset", phyReset, 1'b0);
    checkBit("R1", "coreReset at reset", coreReset, 1'b1);
    checkBit("R1", "ifcReset at reset", ifcReset, 1'b1);
    checkBit("R1", "busy at reset", busy, 1'b0);
    checkBit("R1", "done at reset", done, 1'b0);
    monOn = 1'b1;
    repeat (4) @(negedge clk);
    checkBit("R1", "ifcReset held before start", ifcReset, 1'b1);
    checkBit("R1", "coreReset held before start", coreReset, 1'b1);

    // R3 main timing, with R7 and R10 disturbance mid-run
    runSeq("R3", 3, 2, 4, 2, 1'b1, 1'b1, 1'b1);
    checkBit("R9", "ifcReset released by first start", ifcReset, 1'b0);
    repeat (5) @(negedge clk);
    checkBit("R4", "done held while idle", done, 1'b1);
    // R6 rate zero, R5 zero pre-delay
    runSeq("R6", 0, 3, 2, 0, 1'b1, 1'b1, 1'b0);
    // R5 zero pulse: no PHY assertion, core absent
    runSeq("R5", 2, 0, 1, 3, 1'b0, 1'b1, 1'b0);
    // R8 PHY absent
    runSeq("R8", 5, 5, 5, 4, 1'b1, 1'b0, 1'b0);
    // R5 all delays zero
    runSeq("R5", 0, 0, 0, 9, 1'b0, 1'b1, 1'b0);
    // R10 larger rate, zero post-delay
    runSeq("R10", 1, 2, 0, 5, 1'b0, 1'b1, 1'b1);
    // R9 interface reset pulses
    cfgPulse(1'b1);
    cfgPulse(1'b0);
    cfgPulse(1'b1);
    checkBit("R2", "coreReset idle low", coreReset, 1'b0);
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule